// File: doc/BRIEF.md
# Discrete Output Safe-State Controller

This block sits between a host that commands 32 discrete output points and the drivers that switch them. The points are split into two groups of 16, and each group has its own field supply. The host writes a 32-bit output word over a valid/ready interface. The block turns that word into drive levels, and forces safe states when any of these happen:

- the host stops sending its periodic alive pulse;
- a group's field supply drops;
- the mode switch on the board disagrees with the mode set by software;
- a point reports overcurrent.

It also produces indicator encodings for every point and every group, a 16-bit status word, and a 32-bit per-point protection word.

When the host goes silent, the board switch selects what happens. In force-off mode every point is cleared. In hold mode the last commanded word is kept. Point overcurrent flags arrive asynchronously and are synchronised inside the block. Protection recovers by itself: a point returns to its commanded level once its flag clears. The host interface never applies back-pressure once the block is out of reset. `host_ready` is low during reset and high from the first clock edge after reset is released. A word is taken on any edge where `host_valid` and `host_ready` are both high.

Top module: `dout_guard`

## Requirements
- R1: In force-off mode (`sw_hold`=0, `cfg_hold`=0), if no `comm_alive` pulse arrives for TIMEOUT_MS milliseconds (CLK_KHZ*TIMEOUT_MS cycles), all drives go to 0 and status bit 2 reads 1. A later `comm_alive` pulse restores the commanded drives and clears bit 2.
- R2: In hold mode (`sw_hold`=1, `cfg_hold`=1), the same timeout sets status bit 2 but keeps the last commanded drives. A word accepted while communication is lost still updates the drives.
- R3: While a group's field supply is low, every drive in that group is 0, that group's LED code is 00, and its supply status bit reads 1. Group 0 (points 0-15) reports on bit 4, group 1 (points 16-31) on bit 5.
- R4: After a group's field supply returns, that group's drives stay 0 until a host word is accepted. After reset, all drives are 0 until the first accepted word.
- R5: When `sw_hold` differs from `cfg_hold`, all drives are 0 and status bit 1 reads 1.
- R6: A synchronised overcurrent flag on a commanded-on point clears that drive and sets three things:
  - its bit in `prot_status`;
  - its point LED code to 10 (yellow);
  - its group LED code to 10, and the group's protection status bit (bit 6 for group 0, bit 7 for group 1).
  When the flag clears, the point returns to its commanded level.
- R7: An overcurrent flag on a point commanded off raises no protection fault and no status bit.
- R8: `host_ready` is 0 in reset and 1 afterwards. An accepted word appears on `point_drive` two clock edges after the accepting edge.
- R9: Status bit 0 mirrors `sw_hold`. Status bit 3 reads 1 when `tb_present` is 0. Bits 15:8 read 0.
- R10: In reset, all drives are 0.
- R11: A point LED code is 01 (green) when the point is driven, 00 when it is off and unfaulted, and 10 when it is faulted. A group LED code is 01 when the supply is good and no point in the group is faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_valid | input | 1 | Host output word valid |
| host_ready | output | 1 | Block accepts the word |
| host_data | input | 32 | Commanded output levels, bit i = point i |
| comm_alive | input | 1 | Host alive pulse |
| grp_pwr_ok | input | 2 | Field supply good, per group |
| oc_flag | input | 32 | Asynchronous per-point overcurrent flags |
| sw_hold | input | 1 | Board switch: 1 = hold last state |
| cfg_hold | input | 1 | Software default mode: 1 = hold last state |
| tb_present | input | 1 | Terminal block fitted |
| point_drive | output | 32 | Point drive levels |
| point_led | output | 64 | Point LED codes, 2 bits per point |
| group_led | output | 4 | Group LED codes, 2 bits per group |
| status | output | 16 | Status word |
| prot_status | output | 32 | Per-point protection faults, group 0 in the low half |

## Verification
Each result has a fixed latency from its stimulus:

| Stimulus | Edges until the output reflects it |
|---|---|
| Accepted host word | 2 |
| Supply, switch, configuration or terminal-block change (drives, LEDs, status) | 1 |
| Overcurrent flag (two synchroniser stages plus the output register) | 3 |
| Communication loss, after the timeout counter saturates | 1 |

The vector walk applies inputs at a falling edge and samples five falling edges later, which is past every latency listed above. Directed tests sample at the exact edge where host data should and should not yet show. The timeout is tested with two samples: one well inside the window and one well past it.

// File: rtl/dout_pkg.sv
package dout_pkg;
  typedef enum logic [1:0] {
    LED_OFF    = 2'b00,
    LED_GREEN  = 2'b01,
    LED_YELLOW = 2'b10
  } led_e;
endpackage

// File: rtl/dout_sync.sv
module dout_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/dout_comm_timer.sv
module dout_comm_timer #(
  parameter int CLK_KHZ    = 200000,
  parameter int TIMEOUT_MS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alive,
  output logic lost
);
  localparam int PRE_W = $clog2(CLK_KHZ);
  localparam int MS_W  = $clog2(TIMEOUT_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_KHZ - 1);
  localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(TIMEOUT_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ms_q   <= '0;
      lost_q <= 1'b0;
    end else if (alive) begin
      pre_q  <= '0;
      ms_q   <= '0;
      lost_q <= 1'b0;
    end else if (!lost_q) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (ms_q == MS_LAST) lost_q <= 1'b1;
        else                 ms_q   <= ms_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign lost = lost_q;

  // R1: an alive pulse always clears the loss indication
  assert_alive_clears_loss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    alive |=> !lost);
endmodule

// File: rtl/dout_group.sv
module dout_group import dout_pkg::*; #(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwr_ok,
  input  logic           accept,
  input  logic [N-1:0]   want_cmd,
  input  logic [N-1:0]   oc_s,
  output logic [N-1:0]   drive_q,
  output logic [N-1:0]   fault_q,
  output logic [2*N-1:0] led_q,
  output logic [1:0]     gled_q,
  output logic           flt_any
);
  logic         blk_q;
  logic [N-1:0] want, flt, drv;
  logic [2*N-1:0] led_d;

  // group held dark after supply loss (and after reset) until a word is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       blk_q <= 1'b1;
    else if (!pwr_ok) blk_q <= 1'b1;
    else if (accept)  blk_q <= 1'b0;
  end

  assign want    = want_cmd & {N{pwr_ok & ~blk_q}};
  assign flt     = want & oc_s;
  assign drv     = want & ~oc_s;
  assign flt_any = |flt;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (flt[i])      led_d[2*i +: 2] = LED_YELLOW;
      else if (drv[i]) led_d[2*i +: 2] = LED_GREEN;
      else             led_d[2*i +: 2] = LED_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      fault_q <= '0;
      led_q   <= '0;
      gled_q  <= LED_OFF;
    end else begin
      drive_q <= drv;
      fault_q <= flt;
      led_q   <= led_d;
      if (!pwr_ok)      gled_q <= LED_OFF;
      else if (flt_any) gled_q <= LED_YELLOW;
      else              gled_q <= LED_GREEN;
    end
  end

  // R3: supply low in a cycle leaves the group dark on the next
  assert_dark_on_supply_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> drive_q == '0);

  // R4: supply back without a new word keeps the group dark
  assert_stay_dark_after_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !accept && $past(!pwr_ok)) |=> drive_q == '0);
endmodule

// File: rtl/dout_guard.sv
module dout_guard import dout_pkg::*; #(
  parameter int PTS_PER_GRP = 16,
  parameter int CLK_KHZ     = 200000,
  parameter int TIMEOUT_MS  = 400
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_valid,
  output logic                     host_ready,
  input  logic [2*PTS_PER_GRP-1:0] host_data,
  input  logic                     comm_alive,
  input  logic [1:0]               grp_pwr_ok,
  input  logic [2*PTS_PER_GRP-1:0] oc_flag,
  input  logic                     sw_hold,
  input  logic                     cfg_hold,
  input  logic                     tb_present,
  output logic [2*PTS_PER_GRP-1:0] point_drive,
  output logic [4*PTS_PER_GRP-1:0] point_led,
  output logic [3:0]               group_led,
  output logic [15:0]              status,
  output logic [2*PTS_PER_GRP-1:0] prot_status
);
  localparam int NGRP = 2;
  localparam int NPTS = NGRP * PTS_PER_GRP;

  logic            rdy_q;
  logic [NPTS-1:0] cmd_q;
  logic [NPTS-1:0] oc_s;
  logic [NPTS-1:0] want_cmd;
  logic            lost, mismatch, kill, accept;
  logic [NGRP-1:0] flt_any;
  logic [15:0]     status_q;

  assign accept   = host_valid & rdy_q;
  assign mismatch = sw_hold ^ cfg_hold;
  assign kill     = mismatch | (lost & ~sw_hold);
  assign want_cmd = cmd_q & {NPTS{~kill}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (accept) cmd_q <= host_data;
    end
  end

  dout_sync #(.W(NPTS)) u_oc_sync (
    .clk(clk), .rst_n(rst_n), .d_async(oc_flag), .d_sync(oc_s)
  );

  dout_comm_timer #(.CLK_KHZ(CLK_KHZ), .TIMEOUT_MS(TIMEOUT_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .alive(comm_alive), .lost(lost)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    dout_group #(.N(PTS_PER_GRP)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_ok  (grp_pwr_ok[g]),
      .accept  (accept),
      .want_cmd(want_cmd[g*PTS_PER_GRP +: PTS_PER_GRP]),
      .oc_s    (oc_s[g*PTS_PER_GRP +: PTS_PER_GRP]),
      .drive_q (point_drive[g*PTS_PER_GRP +: PTS_PER_GRP]),
      .fault_q (prot_status[g*PTS_PER_GRP +: PTS_PER_GRP]),
      .led_q   (point_led[2*g*PTS_PER_GRP +: 2*PTS_PER_GRP]),
      .gled_q  (group_led[2*g +: 2]),
      .flt_any (flt_any[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else status_q <= {8'h00, flt_any[1], flt_any[0], ~grp_pwr_ok[1], ~grp_pwr_ok[0],
                      ~tb_present, lost, mismatch, sw_hold};
  end

  assign status     = status_q;
  assign host_ready = rdy_q;

  // R5: mode disagreement darkens every point and is flagged
  assert_mismatch_forces_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hold != cfg_hold) |=> (point_drive == '0) && status[1]);

  // R1: lost communication in force-off mode darkens every point
  assert_timeout_forces_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !sw_hold) |=> point_drive == '0);
endmodule

// File: tb/test_dout_guard.sv
`timescale 1ns/1ps
module test_dout_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic [31:0] host_data = '0;
  logic        comm_alive = 1'b0;
  logic [1:0]  grp_pwr_ok = 2'b11;
  logic [31:0] oc_flag = '0;
  logic        sw_hold = 1'b0, cfg_hold = 1'b0, tb_present = 1'b1;
  logic [31:0] point_drive;
  logic [63:0] point_led;
  logic [3:0]  group_led;
  logic [15:0] status;
  logic [31:0] prot_status;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dout_guard #(.PTS_PER_GRP(16), .CLK_KHZ(2), .TIMEOUT_MS(400)) i_dout_guard (.*);

  typedef struct packed {
    logic        vld;
    logic [31:0] dat;
    logic [1:0]  pwr;
    logic [31:0] oc;
    logic        sw;
    logic        cfg;
    logic        tb;
    logic [31:0] xdrv;
    logic [15:0] xst;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b1, 32'hA5A5_0F0F, 2'b11, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'hA5A5_0F0F, 16'h0000}, // R8 R11
    '{1'b0, 32'h0,         2'b11, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 32'hA5A5_0F0E, 16'h0040}, // R6
    '{1'b0, 32'h0,         2'b11, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'hA5A5_0F0F, 16'h0000}, // R6 recover
    '{1'b1, 32'hA5A5_0F0E, 2'b11, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 32'hA5A5_0F0E, 16'h0000}, // R7
    '{1'b1, 32'hFFFF_0000, 2'b11, 32'h0001_0000, 1'b0, 1'b0, 1'b1, 32'hFFFE_0000, 16'h0080}, // R6 group 1
    '{1'b0, 32'h0,         2'b01, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 16'h0020}, // R3
    '{1'b0, 32'h0,         2'b11, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 16'h0000}, // R4
    '{1'b1, 32'h1234_5678, 2'b11, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h1234_5678, 16'h0000}, // R4
    '{1'b0, 32'h0,         2'b11, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 32'h0000_0000, 16'h0003}, // R5
    '{1'b0, 32'h0,         2'b11, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 32'h1234_5678, 16'h0001}, // R9
    '{1'b0, 32'h0,         2'b11, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 16'h0008}, // R9
    '{1'b0, 32'h0,         2'b10, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h1234_0000, 16'h0010}, // R3
    '{1'b1, 32'h0000_FFFF, 2'b11, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h0000_FFFF, 16'h0000}  // R4
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] d);
    @(negedge clk);
    host_data = d; host_valid = 1'b1; comm_alive = 1'b1;
    @(negedge clk);
    host_valid = 1'b0; comm_alive = 1'b0;
  endtask

  task automatic pulse_alive();
    @(negedge clk); comm_alive = 1'b1;
    @(negedge clk); comm_alive = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 drive in reset", 64'(point_drive), 64'h0);
    check("R8 ready in reset", 64'(host_ready), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 ready after reset", 64'(host_ready), 64'h1);
    check("R9 status idle", 64'(status), 64'h0);

    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      host_valid = VEC[i].vld; host_data = VEC[i].dat; grp_pwr_ok = VEC[i].pwr;
      oc_flag = VEC[i].oc; sw_hold = VEC[i].sw; cfg_hold = VEC[i].cfg;
      tb_present = VEC[i].tb; comm_alive = 1'b1;
      @(negedge clk);
      host_valid = 1'b0; comm_alive = 1'b0;
      repeat (4) @(negedge clk);
      check($sformatf("vector %0d drive", i), 64'(point_drive), 64'(VEC[i].xdrv));
      check($sformatf("vector %0d status", i), 64'(status), 64'(VEC[i].xst));
    end

    // R8: exact latency of an accepted word
    @(negedge clk);
    host_data = 32'h00FF_00FF; host_valid = 1'b1; comm_alive = 1'b1;
    @(negedge clk);
    host_valid = 1'b0; comm_alive = 1'b0;
    check("R8 one edge after accept", 64'(point_drive), 64'h0000_FFFF);
    @(negedge clk);
    check("R8 two edges after accept", 64'(point_drive), 64'h00FF_00FF);

    // R11 and R6: LED codes
    check("R11 point0 green", 64'(point_led[1:0]), 64'h1);
    check("R11 point8 off", 64'(point_led[17:16]), 64'h0);
    check("R11 group0 green", 64'(group_led[1:0]), 64'h1);
    @(negedge clk); oc_flag = 32'h0000_0001;
    repeat (5) @(negedge clk);
    check("R6 point0 yellow", 64'(point_led[1:0]), 64'h2);
    check("R6 group0 yellow", 64'(group_led[1:0]), 64'h2);
    check("R6 group1 green", 64'(group_led[3:2]), 64'h1);
    check("R6 prot_status", 64'(prot_status), 64'h1);
    oc_flag = '0;
    repeat (5) @(negedge clk);
    check("R6 recovered", 64'(point_drive), 64'h00FF_00FF);

    // R1: force-off timeout, 800 cycles at these settings
    pulse_alive();
    repeat (300) @(negedge clk);
    check("R1 before timeout drive", 64'(point_drive), 64'h00FF_00FF);
    check("R1 before timeout status", 64'(status), 64'h0);
    repeat (600) @(negedge clk);
    check("R1 after timeout drive", 64'(point_drive), 64'h0);
    check("R1 after timeout status", 64'(status), 64'h4);
    pulse_alive();
    repeat (3) @(negedge clk);
    check("R1 alive restores drive", 64'(point_drive), 64'h00FF_00FF);
    check("R1 alive clears status", 64'(status), 64'h0);

    // R2: hold-last-state timeout
    @(negedge clk); sw_hold = 1'b1; cfg_hold = 1'b1;
    pulse_alive();
    repeat (900) @(negedge clk);
    check("R2 hold keeps drive", 64'(point_drive), 64'h00FF_00FF);
    check("R2 hold status", 64'(status), 64'h5);
    @(negedge clk); host_data = 32'h0000_00FF; host_valid = 1'b1;
    @(negedge clk); host_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 new word while lost", 64'(point_drive), 64'h0000_00FF);

    // R3: group LED off on supply loss
    @(negedge clk); grp_pwr_ok = 2'b10;
    repeat (3) @(negedge clk);
    check("R3 group0 led off", 64'(group_led[1:0]), 64'h0);
    check("R3 group0 dark", 64'(point_drive), 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule